// File: doc/BRIEF.md
# Serial Grant Chain Bus Arbiter

The block hands ownership of a shared I/O bus to one device at a time. Every device can raise its request, and all requests merge into one shared line toward a central controller. When that line is active and the bus is free, the controller offers a root grant. The grant enters the device nearest the controller and moves down the chain through one pass cell per device. A cell whose device is requesting keeps the grant and becomes the owner. A cell whose device is idle forwards the grant to the next cell. There is no central priority encoder: a device's priority is set only by its position in the chain.

The owner keeps the bus until it pulses its release line. When the controller sees the release, it drops the root grant for at least one cycle. It then offers the grant again if any request is pending. A device cell can be flagged as broken. A broken cell neither takes nor forwards the grant, so every device below it is cut off. If an offer finds no taker, the controller goes back to idle and retries. The scheme is deliberately not fair.

Top module: `dc_arb_bus`

## Requirements
- R1: After reset, `bus_gnt_o`, every bit of `gnt_o` and every bit of `own_o` are 0.
- R2: In idle with any bit of `req_i` set, `bus_gnt_o` is 1 after the next clock edge (the offer cycle).
- R3: The requesting, non-broken device with the lowest index that the grant reaches becomes the owner (`own_o` bit set) on the edge that ends the offer cycle.
- R4: While the root grant is up, bit k of `gnt_o` is 1 exactly when the grant reached cell k and cell k neither owns nor takes it; bits at and below the owner read 0.
- R5: At most one bit of `own_o` is set in any cycle.
- R6: An owner keeps ownership until its own release; dropping its request or a new request from an upstream device does not move ownership.
- R7: A `rel_i` pulse from a device that is not the owner has no effect on `own_o` or `bus_gnt_o`.
- R8: The owner's `rel_i` clears ownership and takes `bus_gnt_o` to 0 on the same edge. The root grant stays low for one cycle, then a new offer starts if requests are pending.
- R9: A device that requests continuously wins every round against devices further down the chain, which wait indefinitely.
- R10: A cell with its `brk_i` bit set never owns and never forwards the grant. An offer that finds no taker returns the controller to idle on the next edge, with `own_o` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NDEV | Per-device bus request, bit 0 nearest the controller |
| rel_i | input | NDEV | Per-device release pulse, honoured only from the owner |
| brk_i | input | NDEV | Per-cell fault flag; a set bit blocks take and forward |
| bus_gnt_o | output | 1 | Root grant driven into cell 0 |
| gnt_o | output | NDEV | Grant forwarded out of each cell |
| own_o | output | NDEV | One-hot-or-zero current owner |

## Verification
The bench builds the chain with NDEV = 6. With six cells there is room for an idle upstream cell, an owner in the middle, and requesters both above and below it. The same chain is long enough to place a broken cell with live requesters on each side. This lets the bench check forwarding past idle cells, no preemption from above, starvation of lower devices, and a fault that cuts off the tail.

// File: rtl/dc_arb_pkg.sv
package dc_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dc_arb_ctrl.sv
module dc_arb_ctrl
  import dc_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_req_i,
  input  logic any_take_i,
  input  logic any_rel_i,
  output logic gnt_o,
  output logic offer_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:  if (any_req_i) state_d = ARB_OFFER;
      ARB_OFFER: state_d = any_take_i ? ARB_BUSY : ARB_IDLE;
      ARB_BUSY:  if (any_rel_i) state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_IDLE;
    else         state_q <= state_d;
  end

  assign offer_o = (state_q == ARB_OFFER);
  assign gnt_o   = (state_q == ARB_OFFER) || (state_q == ARB_BUSY);

  // R2
  offer_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_o && any_req_i) |=> offer_o);
  // R8
  rel_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !offer_o && any_rel_i) |=> !gnt_o);
  // R10
  no_taker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offer_o && !any_take_i) |=> !gnt_o);
endmodule

// File: rtl/dc_arb_cell.sv
module dc_arb_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic offer_i,
  input  logic gnt_i,
  input  logic req_i,
  input  logic rel_i,
  input  logic brk_i,
  output logic gnt_o,
  output logic take_o,
  output logic own_o,
  output logic rel_o
);
  logic own_q;

  // capture only during the offer cycle; afterwards the chain is frozen by own_q
  assign take_o = offer_i && gnt_i && req_i && !brk_i;
  assign gnt_o  = gnt_i && !brk_i && !own_q && !take_o;
  assign rel_o  = own_q && rel_i;
  assign own_o  = own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      own_q <= 1'b0;
    else if (take_o)  own_q <= 1'b1;
    else if (rel_o)   own_q <= 1'b0;
  end

  // R6
  own_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q && !rel_i) |=> own_q);
  // R4
  pass_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> gnt_i);
endmodule

// File: rtl/dc_arb_bus.sv
module dc_arb_bus #(
  parameter int NDEV = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NDEV-1:0] req_i,
  input  logic [NDEV-1:0] rel_i,
  input  logic [NDEV-1:0] brk_i,
  output logic            bus_gnt_o,
  output logic [NDEV-1:0] gnt_o,
  output logic [NDEV-1:0] own_o
);
  localparam int CHAIN_W = NDEV + 1;

  logic [CHAIN_W-1:0] chain;
  logic [NDEV-1:0]    take, rel_own;
  logic               root_gnt, offer;

  dc_arb_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_req_i  (|req_i),
    .any_take_i (|take),
    .any_rel_i  (|rel_own),
    .gnt_o      (root_gnt),
    .offer_o    (offer)
  );

  assign chain[0] = root_gnt;

  for (genvar k = 0; k < NDEV; k++) begin : g_cell
    dc_arb_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .offer_i (offer),
      .gnt_i   (chain[k]),
      .req_i   (req_i[k]),
      .rel_i   (rel_i[k]),
      .brk_i   (brk_i[k]),
      .gnt_o   (chain[k+1]),
      .take_o  (take[k]),
      .own_o   (own_o[k]),
      .rel_o   (rel_own[k])
    );
  end

  assign bus_gnt_o = root_gnt;
  assign gnt_o     = chain[CHAIN_W-1:1];

  // R5
  one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_o));
  // R5
  one_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));
endmodule

// File: tb/sim_dc_arb_bus.sv
module sim_dc_arb_bus;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, rel = '0, brk = '0;
  logic         bus_gnt;
  logic [N-1:0] gnt, own;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dc_arb_bus #(.NDEV(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rel_i(rel), .brk_i(brk),
    .bus_gnt_o(bus_gnt), .gnt_o(gnt), .own_o(own)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic pulse_rel(input int k);
    rel[k] = 1'b1;
    step(1);
    rel[k] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 bus_gnt", N'(bus_gnt), '0);
    chk("R1 gnt", gnt, '0);
    chk("R1 own", own, '0);
  endtask

  task automatic t_single_hold;
    req = 6'b001000;
    step(1);
    chk("R2 offer", N'(bus_gnt), N'(1));
    chk("R4 pass offer", gnt, 6'b000111);
    step(1);
    chk("R3 owner", own, 6'b001000);
    chk("R4 pass busy", gnt, 6'b000111);
    req = 6'b000001;
    step(3);
    chk("R6 no preempt", own, 6'b001000);
    chk("R6 grant held", N'(bus_gnt), N'(1));
    chk("R5 onehot", N'($countones(own)), N'(1));
    rel[1] = 1'b1; rel[5] = 1'b1;
    step(2);
    rel = '0;
    chk("R7 own kept", own, 6'b001000);
    chk("R7 grant kept", N'(bus_gnt), N'(1));
  endtask

  task automatic t_release;
    pulse_rel(3);
    chk("R8 gap grant", N'(bus_gnt), '0);
    chk("R8 own clear", own, '0);
    step(1);
    chk("R8 reoffer", N'(bus_gnt), N'(1));
    step(1);
    chk("R8 new owner", own, 6'b000001);
  endtask

  task automatic t_starve;
    req = 6'b010101;
    for (int r = 0; r < 3; r++) begin
      pulse_rel(0);
      step(2);
      chk("R9 upstream wins", own, 6'b000001);
    end
    req = 6'b010100;
    pulse_rel(0);
    step(2);
    chk("R9 next in line", own, 6'b000100);
    req = 6'b100010;
    pulse_rel(2);
    step(2);
    chk("R3 lowest index", own, 6'b000010);
    req = '0;
    pulse_rel(1);
    step(2);
    chk("R8 idle", N'(bus_gnt), '0);
    chk("R1 own idle", own, '0);
  endtask

  task automatic t_broken;
    brk = 6'b000100;
    req = 6'b010000;
    step(1);
    chk("R10 offer", N'(bus_gnt), N'(1));
    chk("R10 cut chain", gnt, 6'b000011);
    step(1);
    chk("R10 no owner", own, '0);
    chk("R10 back idle", N'(bus_gnt), '0);
    req = 6'b010110;
    step(2);
    chk("R10 upstream ok", own, 6'b000010);
    req = 6'b010100;
    pulse_rel(1);
    step(2);
    chk("R10 broken never owns", own, '0);
    req = '0;
    brk = '0;
    step(3);
  endtask

  initial begin
    step(2);
    t_reset;
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_single_hold;
    t_release;
    t_starve;
    t_broken;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule